// File: doc/BRIEF.md
# Interrupt Request Flag Bank with Per-Flag Clear Policies

This block holds a set of interrupt request flags. A hardware event pulse on a flag's input latches the flag, which then stays pending until it is cleared. Each flag has an enable bit, and a single global enable gates the whole bank. The block drives one request line and the index of the highest-priority pending source. Software reaches the flags, the enables and the global enable through a small register port with a select, a write strobe, write data and combinational read data.

Each flag has a fixed clear policy, chosen per bit by a parameter. Every flag can be cleared by writing a 1 to its bit in the flag register. A flag that is set to clear on acknowledge is also cleared when the core takes its vector. A flag that is set to clear on data read is also cleared by a strobe that marks a read of its associated data register. A write-one-only flag is never cleared by hardware. Its software clear is also sent out as a one-cycle pulse, so that a bus handshake can go ahead. Writing 0 to a flag bit never changes it, so one full-register write can clear a single source with no read-modify-write and with no risk of dropping another pending request.

Taking a vector turns the global enable off. The handler must clear its flag before it turns the enable back on, or the request is raised again.

Top module: `irq_flag_bank`

## Requirements
- R1: An event pulse on `event_i[i]` sets flag i at the next clock edge. The flag then stays 1 until one of the clears in R3, R5 or R6 removes it.
- R2: `irq_o` is 1 exactly when the global enable is on and at least one flag is 1 with its enable bit also 1. It follows the registered state with no extra delay.
- R3: A write to the flag register (select 0) with data bit i equal to 1 clears flag i at the next edge. This applies under every clear policy.
- R4: A data bit of 0 in a flag-register write leaves that flag unchanged. A write of all zeros therefore changes no flag.
- R5: When `ack_i` is high, the global enable turns off at the next edge. If `irq_o` is also high and the flag named by `vec_o` has policy 1 (clear on acknowledge), that flag is cleared. A flag with policy 0 or 2 stays set. The acknowledge takes priority over a global-enable write in the same cycle.
- R6: A pulse on `data_rd_i[i]` clears flag i only when its policy is 2 (clear on data read). Under any other policy the pulse has no effect.
- R7: When a flag with policy 0 (write-one only) is 1 and is cleared by a software write of 1, `clr_pulse_o[i]` is high for exactly the one cycle after that write. It is 0 at all other times.
- R8: If an event and any clear reach the same flag in the same cycle, the flag stays 1 and no pulse is produced.
- R9: While `irq_o` is 1, `vec_o` is the lowest index whose flag and enable bit are both 1. While `irq_o` is 0, `vec_o` is 0.
- R10: Select 0 reads the flags, select 1 reads the enables, select 2 reads the global enable in bit 0 with all other bits 0, and select 3 reads 0. Writes to select 1 replace the enables, and writes to select 2 load the global enable from bit 0. Reads have no side effects. After reset all flags, all enables and the global enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | N_FLAGS | Per-flag event pulses |
| reg_sel_i | input | 2 | Register select: 0 flags, 1 enables, 2 control, 3 none |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | N_FLAGS | Write data |
| reg_rdata_o | output | N_FLAGS | Read data of the selected register (combinational) |
| ack_i | input | 1 | Vector acknowledge (handler entry) |
| data_rd_i | input | N_FLAGS | Per-flag strobes marking a read of the associated data register |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | IDX_W | Index of the lowest pending and enabled flag |
| clr_pulse_o | output | N_FLAGS | One-cycle pulses for software clears of write-one-only flags |

## Verification
Flags, enables, the global enable and the clear pulses change at the clock edge that samples their cause. `irq_o`, `vec_o` and `reg_rdata_o` are combinational from that registered state, so every result of a stimulus is due in the cycle right after the edge that sampled it. The bench drives all inputs on the falling edge and advances its own model over exactly one rising edge. It then compares request, vector, pulse vector and the selected read data on the following falling edge. A read needs no clock, so directed readbacks change only the select and sample after a short settle delay within the same low phase.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] POL_W1C_ONLY = 2'd0;
    localparam logic [1:0] POL_ON_ACK   = 2'd1;
    localparam logic [1:0] POL_ON_DRD   = 2'd2;

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_flag_pkg::*;
#(
    parameter logic [1:0] POLICY = POL_W1C_ONLY
) (
    input  logic flag_q_i,
    input  logic event_i,
    input  logic sw_clr_i,
    input  logic ack_hit_i,
    input  logic drd_i,
    output logic flag_d_o,
    output logic pulse_d_o
);

    logic hw_clr;

    generate
        if (POLICY == POL_ON_ACK) begin : g_ack
            assign hw_clr = ack_hit_i;
        end else if (POLICY == POL_ON_DRD) begin : g_drd
            assign hw_clr = drd_i;
        end else begin : g_w1c
            assign hw_clr = 1'b0;
        end
    endgenerate

    always_comb begin
        flag_d_o  = event_i | (flag_q_i & ~(sw_clr_i | hw_clr));
        pulse_d_o = 1'b0;
        if (POLICY != POL_ON_ACK && POLICY != POL_ON_DRD) begin
            pulse_d_o = sw_clr_i & flag_q_i & ~event_i;
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_IN  = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_IN-1:0]  req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int                 N_FLAGS    = 8,
    parameter int                 IDX_W      = (N_FLAGS > 1) ? $clog2(N_FLAGS) : 1,
    parameter logic [2*N_FLAGS-1:0] CLR_POLICY = 16'hA540
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_FLAGS-1:0] event_i,
    input  logic [1:0]         reg_sel_i,
    input  logic               reg_we_i,
    input  logic [N_FLAGS-1:0] reg_wdata_i,
    output logic [N_FLAGS-1:0] reg_rdata_o,
    input  logic               ack_i,
    input  logic [N_FLAGS-1:0] data_rd_i,
    output logic               irq_o,
    output logic [IDX_W-1:0]   vec_o,
    output logic [N_FLAGS-1:0] clr_pulse_o
);

    localparam logic [N_FLAGS-1:0] ONE_V = N_FLAGS'(1);

    typedef struct packed {
        logic [N_FLAGS-1:0] flags;
        logic [N_FLAGS-1:0] en;
        logic               gie;
        logic [N_FLAGS-1:0] pulse;
    } state_t;

    state_t state_d, state_q;

    reg_sel_e           sel;
    logic [N_FLAGS-1:0] pend;
    logic               pend_any;
    logic [IDX_W-1:0]   pend_idx;
    logic [N_FLAGS-1:0] sw_clr;
    logic [N_FLAGS-1:0] ack_hit;
    logic [N_FLAGS-1:0] flag_nx;
    logic [N_FLAGS-1:0] pulse_nx;

    assign sel  = reg_sel_e'(reg_sel_i);
    assign pend = state_q.flags & state_q.en;

    irq_prio_enc #(
        .N_IN  (N_FLAGS),
        .IDX_W (IDX_W)
    ) prio_i (
        .req_i (pend),
        .any_o (pend_any),
        .idx_o (pend_idx)
    );

    assign irq_o       = pend_any & state_q.gie;
    assign vec_o       = irq_o ? pend_idx : '0;
    assign clr_pulse_o = state_q.pulse;

    always_comb begin
        sw_clr  = (reg_we_i && sel == SEL_FLAGS) ? reg_wdata_i : '0;
        ack_hit = '0;
        if (ack_i && irq_o) ack_hit = ONE_V << vec_o;
    end

    generate
        for (genvar g = 0; g < N_FLAGS; g++) begin : g_cell
            irq_flag_cell #(
                .POLICY (CLR_POLICY[2*g +: 2])
            ) cell_i (
                .flag_q_i  (state_q.flags[g]),
                .event_i   (event_i[g]),
                .sw_clr_i  (sw_clr[g]),
                .ack_hit_i (ack_hit[g]),
                .drd_i     (data_rd_i[g]),
                .flag_d_o  (flag_nx[g]),
                .pulse_d_o (pulse_nx[g])
            );
        end
    endgenerate

    always_comb begin
        state_d       = state_q;
        state_d.flags = flag_nx;
        state_d.pulse = pulse_nx;
        if (reg_we_i && sel == SEL_ENABLE) state_d.en = reg_wdata_i;
        if (ack_i) begin
            state_d.gie = 1'b0;
        end else if (reg_we_i && sel == SEL_CTRL) begin
            state_d.gie = reg_wdata_i[0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAGS:  reg_rdata_o = state_q.flags;
            SEL_ENABLE: reg_rdata_o = state_q.en;
            SEL_CTRL:   reg_rdata_o = {{(N_FLAGS-1){1'b0}}, state_q.gie};
            default:    reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    // R1: an event always leaves its flag set
    assert_event_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|event_i) |=> ((state_q.flags & $past(event_i)) == $past(event_i)));

    // R4: writing zeros to the flag register never drops a pending flag
    assert_zero_write_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_sel_i == 2'd0 && reg_wdata_i == '0 && data_rd_i == '0 && !ack_i)
        |=> ((state_q.flags & $past(state_q.flags)) == $past(state_q.flags)));

    // R5: acknowledge turns the global enable off
    assert_ack_gie_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> !state_q.gie);

    // R9: the vector names the lowest pending enabled source
    assert_vec_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (pend[vec_o] && ((pend & ((ONE_V << vec_o) - ONE_V)) == '0)));

    // R7: a clear pulse only follows a flag-register write
    assert_pulse_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|clr_pulse_o) |-> $past(reg_we_i && reg_sel_i == 2'd0));

endmodule

// File: tb/irq_flag_bank_tb_top.sv
`timescale 1ns/1ps
module irq_flag_bank_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam logic [2*N-1:0] POL = 16'hA540;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  event_i = '0;
    logic [1:0]    reg_sel = 2'd0;
    logic          reg_we = 1'b0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          ack = 1'b0;
    logic [N-1:0]  data_rd = '0;
    logic          irq;
    logic [IW-1:0] vec;
    logic [N-1:0]  clr_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_flags, m_en, m_pulse;
    logic         m_gie;

    always #2.5 clk = ~clk;

    irq_flag_bank #(.N_FLAGS(N), .IDX_W(IW), .CLR_POLICY(POL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .event_i(event_i), .reg_sel_i(reg_sel),
        .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .ack_i(ack), .data_rd_i(data_rd), .irq_o(irq), .vec_o(vec),
        .clr_pulse_o(clr_pulse)
    );

    function automatic logic [1:0] pol_of(int i);
        return POL[2*i +: 2];
    endfunction

    function automatic logic exp_irq();
        return m_gie && ((m_flags & m_en) != '0);
    endfunction

    function automatic logic [IW-1:0] exp_vec();
        if (!exp_irq()) return '0;
        for (int i = 0; i < N; i++) if (m_flags[i] && m_en[i]) return IW'(i);
        return '0;
    endfunction

    function automatic logic [N-1:0] exp_rdata(logic [1:0] s);
        case (s)
            2'd0:    return m_flags;
            2'd1:    return m_en;
            2'd2:    return {{(N-1){1'b0}}, m_gie};
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [N-1:0] nf, np;
        logic         irq_c;
        logic [IW-1:0] v;
        bit clr;
        irq_c = exp_irq();
        v = exp_vec();
        for (int i = 0; i < N; i++) begin
            clr = (reg_we && reg_sel == 2'd0 && reg_wdata[i])
               || (ack && irq_c && v == IW'(i) && pol_of(i) == 2'd1)
               || (data_rd[i] && pol_of(i) == 2'd2);
            nf[i] = event_i[i] | (m_flags[i] & !clr);
            np[i] = (pol_of(i) == 2'd0) && reg_we && reg_sel == 2'd0
                    && reg_wdata[i] && m_flags[i] && !event_i[i];
        end
        m_flags = nf;
        m_pulse = np;
        if (reg_we && reg_sel == 2'd1) m_en = reg_wdata;
        if (ack) m_gie = 1'b0;
        else if (reg_we && reg_sel == 2'd2) m_gie = reg_wdata[0];
    endtask

    task automatic idle();
        event_i = '0; reg_we = 1'b0; reg_wdata = '0; ack = 1'b0; data_rd = '0; reg_sel = 2'd0;
    endtask

    // one clock: model advances over the edge, outputs compared on the falling edge
    task automatic step();
        model_update();
        @(posedge clk);
        @(negedge clk);
        chk(irq === exp_irq(), "R2 irq", irq, exp_irq());
        chk(vec === exp_vec(), "R9 vec", vec, exp_vec());
        chk(clr_pulse === m_pulse, "R7 pulse", clr_pulse, m_pulse);
        chk(reg_rdata === exp_rdata(reg_sel), "R10 rdata", reg_rdata, exp_rdata(reg_sel));
        idle();
    endtask

    task automatic rd(input logic [1:0] s, output logic [N-1:0] v);
        reg_sel = s;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
        reg_sel = s; reg_we = 1'b1; reg_wdata = d;
        step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd20240611));
        m_flags = '0; m_en = '0; m_gie = 1'b0; m_pulse = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd(2'd0, v); chk(v === '0, "R10 reset flags", v, 0);
        rd(2'd1, v); chk(v === '0, "R10 reset enables", v, 0);
        rd(2'd2, v); chk(v === '0, "R10 reset gie", v, 0);
        chk(irq === 1'b0, "R2 reset irq", irq, 0);

        wr(2'd1, '1);
        wr(2'd2, 8'h01);
        event_i = 8'h20; step();
        rd(2'd0, v); chk(v === 8'h20, "R1 flag set", v, 8'h20);
        chk(vec === 3'd5 && irq, "R9 vec 5", vec, 5);
        event_i = 8'h04; step();
        chk(vec === 3'd2, "R9 lower index wins", vec, 2);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk(v === 8'h24, "R4 zero write keeps flags", v, 8'h24);
        ack = 1'b1; step();
        rd(2'd0, v); chk(v === 8'h24, "R5 policy0 flag kept on ack", v, 8'h24);
        rd(2'd2, v); chk(v === 8'h00, "R5 gie off after ack", v, 0);
        wr(2'd0, 8'h04);
        chk(clr_pulse === 8'h04, "R7 pulse after w1c", clr_pulse, 8'h04);
        rd(2'd0, v); chk(v === 8'h20, "R3 w1c clears", v, 8'h20);
        step();
        chk(clr_pulse === 8'h00, "R7 pulse single cycle", clr_pulse, 0);
        wr(2'd2, 8'h01);
        ack = 1'b1; step();
        rd(2'd0, v); chk(v === 8'h00, "R5 ack clears policy1 flag", v, 0);
        event_i = 8'h88; step();
        data_rd = 8'h88; step();
        rd(2'd0, v); chk(v === 8'h08, "R6 data read clears only policy2", v, 8'h08);
        event_i = 8'h01; step();
        reg_sel = 2'd0; reg_we = 1'b1; reg_wdata = 8'h01; event_i = 8'h01; step();
        rd(2'd0, v); chk(v[0] === 1'b1, "R8 event beats clear", v[0], 1);
        chk(clr_pulse === 8'h00, "R8 no pulse when event wins", clr_pulse, 0);
        ack = 1'b1; reg_sel = 2'd2; reg_we = 1'b1; reg_wdata = 8'h01; step();
        rd(2'd2, v); chk(v === 8'h00, "R5 ack beats gie write", v, 0);

        for (int n = 0; n < 3000; n++) begin
            event_i = N'($urandom & $urandom & $urandom);
            reg_sel = 2'($urandom);
            reg_we  = ($urandom % 3) == 0;
            reg_wdata = N'($urandom);
            if (reg_sel == 2'd2 && ($urandom % 2)) reg_wdata[0] = 1'b1;
            ack = ($urandom % 6) == 0;
            data_rd = N'($urandom & $urandom);
            step();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule